// File: doc/BRIEF.md
# DDR SDRAM Command and Address Encoder

This block accepts abstract memory requests through a valid/ready handshake and turns each one into a registered command word for a four-bank double-data-rate SDRAM: an active-low chip select, the three active-low row, column and write-enable strobes, two bank bits and a 13-bit address bus. Supported requests are row activation, read, write, precharge of one bank or all banks, auto refresh and mode register load.

The encoder keeps one open-row flag per bank. It uses these flags to refuse requests the device would mishandle: a column access to a closed bank, an activation of a bank that is already open, and a refresh while any bank is open. A refused request is still taken from the requester. It produces a one-cycle error pulse and no command, and the chip select stays high. For column accesses, a small burst counter holds the handshake off for half the burst length. When that window ends, the counter closes the bank if the access asked for auto-precharge. The burst length is taken from mode register loads. Column bits are placed around address bit 10, which carries the auto-precharge or precharge-all flag. Which bits are used depends on the device data width parameter.

Top module: `ddr_cmd_encoder`

## Requirements
- R1: Reset behaviour. While and after reset, csN, rasN, casN and weN are 1, ba and addr are 0, reqErr is 0, bankOpen is 0 and reqReady is 1. The burst length is 2 after reset.
- R2: Strobe encoding and chip select. Strobes are written {rasN,casN,weN}. Activate is 011, read is 101, write is 100, precharge is 010, refresh is 001 and mode load is 000, each with csN=0. In every cycle with no issued command, the encoder drives deselect: csN=1, all strobes 1, ba=0 and addr=0.
- R3: Output timing. A request accepted at a rising edge (reqValid and reqReady both high) appears on the pins right after that edge, for exactly one cycle. The next cycle is deselect unless another request is accepted.
- R4: Activate. reqOp 0 drives addr = reqRow and ba = reqBank, with ba[0] as the low-order bank bit. It marks that bank open in bankOpen.
- R5: Read and write. Read is reqOp 1 and write is reqOp 2. With the default x8 width (DEV_WIDTH=8), addr[9:0] = reqCol[9:0], addr[10] = reqAutoPre, addr[11] = reqCol[10] and addr[12] = 0. ba = reqBank.
- R6: Precharge. reqOp 3 drives addr[10] = reqAutoPre and all other address bits 0, with ba = reqBank. With addr[10]=1 it clears every bankOpen bit; with addr[10]=0 it clears only the bank on ba.
- R7: Bank state checks. The following requests are refused: a read or write to a bank whose bankOpen bit is 0, and an activate to a bank whose bit is 1. A refused request pulses reqErr for the cycle after acceptance, issues no command (deselect, per R2) and leaves bankOpen unchanged.
- R8: Refresh and unused codes. Refresh (reqOp 4) drives addr=0 and ba=reqBank, and is accepted only when bankOpen is 0. Otherwise it is refused as in R7. Codes 6 and 7 are always refused as in R7.
- R9: Burst window. After an issued read or write, reqReady is 0 for BL/2 cycles and then returns to 1. If reqAutoPre was 1, the bank's bankOpen bit clears at the same edge that reqReady returns.
- R10: Mode load. reqOp 5 drives addr = reqRow and ba = reqBank. When reqBank is 0, reqRow[2:0] sets the burst length: 1 gives 2, 2 gives 4, 3 gives 8. Any other value, or a nonzero bank, leaves the burst length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Encoder can take a request |
| reqOp | input | 3 | Request code (0 act, 1 read, 2 write, 3 precharge, 4 refresh, 5 mode load) |
| reqBank | input | 2 | Target bank |
| reqRow | input | 13 | Row address, or mode value for a mode load |
| reqCol | input | COL_W (11 at default) | Burst start column |
| reqAutoPre | input | 1 | Auto-precharge on read/write, all-bank on precharge |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank bits |
| addr | output | 13 | Address bus |
| reqErr | output | 1 | Refused-request pulse |
| bankOpen | output | 4 | One open-row flag per bank |

## Verification
Directed sequences cover one case of each kind. Each refusal is issued against a bank state chosen to trigger it. A column value is set with bit 10 high, so that placement above address bit 10 shows up if it goes wrong. A precharge-all is issued with all four banks open. Mode loads set several burst lengths and then check the length of the ready-low window. A seeded random stream of all eight request codes over random banks, rows, columns and flags follows. In that stream, legal and refused requests fall next to each other, and auto-precharge closures happen between other commands. This tells apart errors in how the bank state is tracked from errors in how the command is encoded.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  // request codes
  localparam logic [2:0] OP_ACT = 3'd0;
  localparam logic [2:0] OP_RD  = 3'd1;
  localparam logic [2:0] OP_WR  = 3'd2;
  localparam logic [2:0] OP_PRE = 3'd3;
  localparam logic [2:0] OP_REF = 3'd4;
  localparam logic [2:0] OP_MRS = 3'd5;

  // {rasN, casN, weN}
  localparam logic [2:0] CMD_ACT  = 3'b011;
  localparam logic [2:0] CMD_RD   = 3'b101;
  localparam logic [2:0] CMD_WR   = 3'b100;
  localparam logic [2:0] CMD_PRE  = 3'b010;
  localparam logic [2:0] CMD_REF  = 3'b001;
  localparam logic [2:0] CMD_MRS  = 3'b000;
  localparam logic [2:0] CMD_IDLE = 3'b111;

  typedef enum logic [1:0] {
    ADDR_ZERO = 2'd0,
    ADDR_ROW  = 2'd1,
    ADDR_COL  = 2'd2,
    ADDR_PRE  = 2'd3
  } addrSel_e;

  typedef struct packed {
    logic     issue;
    logic [2:0] cmd;
    addrSel_e addrSel;
    logic     flag;
  } cmdStrobe_t;

endpackage

// File: rtl/ddr_cmd_ctrl.sv
module ddr_cmd_ctrl
  import ddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              reqAutoPre,
  input  logic [2:0]        modeLow,
  output logic              reqReady,
  output logic              reqErr,
  output logic [NUM_BANKS-1:0] bankOpen,
  output cmdStrobe_t        strobe
);

  localparam logic [CNT_W-1:0] HALF_BL2 = CNT_W'(1);
  localparam logic [CNT_W-1:0] HALF_BL4 = CNT_W'(2);
  localparam logic [CNT_W-1:0] HALF_BL8 = CNT_W'(4);

  logic [CNT_W-1:0]  burstCnt;
  logic [CNT_W-1:0]  blHalf;
  logic              apPending;
  logic [BANK_W-1:0] apBank;
  logic              accept;
  logic              legal;
  logic [2:0]        cmdSel;
  addrSel_e          addrSel;

  assign reqReady = (burstCnt == '0);
  assign accept   = reqValid && reqReady;

  always_comb begin
    legal   = 1'b0;
    cmdSel  = CMD_IDLE;
    addrSel = ADDR_ZERO;
    case (reqOp)
      OP_ACT: begin legal = !bankOpen[reqBank]; cmdSel = CMD_ACT; addrSel = ADDR_ROW; end
      OP_RD:  begin legal = bankOpen[reqBank];  cmdSel = CMD_RD;  addrSel = ADDR_COL; end
      OP_WR:  begin legal = bankOpen[reqBank];  cmdSel = CMD_WR;  addrSel = ADDR_COL; end
      OP_PRE: begin legal = 1'b1;               cmdSel = CMD_PRE; addrSel = ADDR_PRE; end
      OP_REF: begin legal = (bankOpen == '0);   cmdSel = CMD_REF; addrSel = ADDR_ZERO; end
      OP_MRS: begin legal = 1'b1;               cmdSel = CMD_MRS; addrSel = ADDR_ROW; end
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    strobe.issue   = accept && legal;
    strobe.cmd     = cmdSel;
    strobe.addrSel = addrSel;
    strobe.flag    = reqAutoPre;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstCnt  <= '0;
      blHalf    <= HALF_BL2;
      apPending <= 1'b0;
      apBank    <= '0;
      bankOpen  <= '0;
      reqErr    <= 1'b0;
    end else begin
      reqErr <= accept && !legal;
      if (burstCnt != '0) begin
        burstCnt <= burstCnt - 1'b1;
        if (burstCnt == CNT_W'(1) && apPending) begin
          bankOpen[apBank] <= 1'b0;
          apPending        <= 1'b0;
        end
      end
      if (accept && legal) begin
        case (reqOp)
          OP_ACT: bankOpen[reqBank] <= 1'b1;
          OP_RD, OP_WR: begin
            burstCnt  <= blHalf;
            apPending <= reqAutoPre;
            apBank    <= reqBank;
          end
          OP_PRE: begin
            if (reqAutoPre) bankOpen <= '0;
            else            bankOpen[reqBank] <= 1'b0;
          end
          OP_MRS: begin
            if (reqBank == '0) begin
              case (modeLow)
                3'd1:    blHalf <= HALF_BL2;
                3'd2:    blHalf <= HALF_BL4;
                3'd3:    blHalf <= HALF_BL8;
                default: blHalf <= blHalf;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  // a refused request never leaves a column window or bank change behind
  assert_err_keeps_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> $stable(bankOpen) || $past(burstCnt) != '0);

endmodule

// File: rtl/ddr_cmd_datapath.sv
module ddr_cmd_datapath
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 11,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] colAddr;
  logic [ADDR_W-1:0] preAddr;
  logic [ADDR_W-1:0] nextAddr;

  // column bits fill the address bus, skipping the flag position
  for (genvar i = 0; i < ADDR_W; i++) begin : g_colPack
    if (i == AP_BIT) begin : g_flag
      assign colAddr[i] = strobe.flag;
    end else if (i < AP_BIT) begin : g_low
      if (i < COL_W) begin : g_used
        assign colAddr[i] = reqCol[i];
      end else begin : g_pad
        assign colAddr[i] = 1'b0;
      end
    end else begin : g_high
      if (i - 1 < COL_W) begin : g_used
        assign colAddr[i] = reqCol[i-1];
      end else begin : g_pad
        assign colAddr[i] = 1'b0;
      end
    end
  end

  always_comb begin
    preAddr         = '0;
    preAddr[AP_BIT] = strobe.flag;
    case (strobe.addrSel)
      ADDR_ROW: nextAddr = reqRow;
      ADDR_COL: nextAddr = colAddr;
      ADDR_PRE: nextAddr = preAddr;
      default:  nextAddr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.issue) begin
      csN              <= 1'b1;
      {rasN, casN, weN} <= CMD_IDLE;
      ba               <= '0;
      addr             <= '0;
    end else begin
      csN              <= 1'b0;
      {rasN, casN, weN} <= strobe.cmd;
      ba               <= reqBank;
      addr             <= nextAddr;
    end
  end

  // deselect cycles carry no stray strobe
  assert_idle_strobes_R2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (rasN && casN && weN && addr == '0));

endmodule

// File: rtl/ddr_cmd_encoder.sv
module ddr_cmd_encoder
  import ddr_cmd_pkg::*;
#(
  parameter int DEV_WIDTH = 8,
  parameter int ADDR_W    = 13,
  parameter int NUM_BANKS = 4,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = (DEV_WIDTH == 4) ? 12 : (DEV_WIDTH == 8) ? 11 : 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [2:0]           reqOp,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ADDR_W-1:0]    reqRow,
  input  logic [COL_W-1:0]     reqCol,
  input  logic                 reqAutoPre,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [BANK_W-1:0]    ba,
  output logic [ADDR_W-1:0]    addr,
  output logic                 reqErr,
  output logic [NUM_BANKS-1:0] bankOpen
);

  cmdStrobe_t strobe;

  ddr_cmd_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .CNT_W    (3)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqBank   (reqBank),
    .reqAutoPre(reqAutoPre),
    .modeLow   (reqRow[2:0]),
    .reqReady  (reqReady),
    .reqErr    (reqErr),
    .bankOpen  (bankOpen),
    .strobe    (strobe)
  );

  ddr_cmd_datapath #(
    .ADDR_W(ADDR_W),
    .COL_W (COL_W),
    .BANK_W(BANK_W),
    .AP_BIT(AP_BIT)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqBank(reqBank),
    .reqRow (reqRow),
    .reqCol (reqCol),
    .csN    (csN),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN),
    .ba     (ba),
    .addr   (addr)
  );

  // refused request issues nothing
  assert_err_no_cmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> csN);

  // column access only reaches an open bank
  assert_col_needs_open_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rasN && !casN) |-> bankOpen[ba]);

  // activation leaves its bank marked open
  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && weN) |-> bankOpen[ba]);

  // precharge of all banks leaves none open
  assert_pre_all_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN && addr[AP_BIT]) |-> (bankOpen == '0));

  // refresh only with every bank closed
  assert_ref_all_closed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && weN) |-> (bankOpen == '0));

  // a column command starts the burst window
  assert_burst_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rasN && !casN) |-> !reqReady);

endmodule

// File: tb/test_ddr_cmd_encoder.sv
`timescale 1ns/1ps
module test_ddr_cmd_encoder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [2:0]  reqOp;
  logic [1:0]  reqBank;
  logic [12:0] reqRow;
  logic [10:0] reqCol;
  logic        reqAutoPre;
  logic        csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        reqErr;
  logic [3:0]  bankOpen;

  int checks = 0;
  int errors = 0;
  logic [3:0] mOpen;
  int mBl;

  always #2.5 clk = ~clk;

  ddr_cmd_encoder i_ddr_cmd_encoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqAutoPre(reqAutoPre), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .reqErr(reqErr), .bankOpen(bankOpen)
  );

  localparam logic [18:0] DESEL = {1'b1, 3'b111, 2'b00, 13'h0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] packCol(input logic [10:0] col, input bit ap);
    logic [12:0] a;
    a = '0;
    a[9:0] = col[9:0];
    a[10]  = ap;
    a[11]  = col[10];
    return a;
  endfunction

  function automatic logic [18:0] pinsNow();
    return {csN, rasN, casN, weN, ba, addr};
  endfunction

  function automatic bit isLegal(input int op, input int bank);
    case (op)
      0: return !mOpen[bank];
      1, 2: return mOpen[bank];
      3, 5: return 1'b1;
      4: return mOpen == 4'h0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [18:0] expPins(input int op, input int bank, input logic [12:0] row,
                                          input logic [10:0] col, input bit ap);
    logic [12:0] preA;
    preA = '0;
    preA[10] = ap;
    case (op)
      0: return {1'b0, 3'b011, 2'(bank), row};
      1: return {1'b0, 3'b101, 2'(bank), packCol(col, ap)};
      2: return {1'b0, 3'b100, 2'(bank), packCol(col, ap)};
      3: return {1'b0, 3'b010, 2'(bank), preA};
      4: return {1'b0, 3'b001, 2'(bank), 13'h0};
      default: return {1'b0, 3'b000, 2'(bank), row};
    endcase
  endfunction

  function automatic string opTag(input int op);
    case (op)
      0: return "R4";
      1, 2: return "R5";
      3: return "R6";
      4: return "R8";
      5: return "R10";
      default: return "R8";
    endcase
  endfunction

  // called at a negedge with reqReady high
  task automatic doReq(input int op, input int bank, input logic [12:0] row,
                       input logic [10:0] col, input bit ap);
    bit legal;
    logic [18:0] e;
    string t;
    legal = isLegal(op, bank);
    e = legal ? expPins(op, bank, row, col, ap) : DESEL;
    t = legal ? $sformatf("R2 R3 %s", opTag(op)) : $sformatf("R7 %s", opTag(op));
    reqValid = 1'b1; reqOp = 3'(op); reqBank = 2'(bank);
    reqRow = row; reqCol = col; reqAutoPre = ap;
    @(negedge clk);
    reqValid = 1'b0;
    chk(t, 32'(pinsNow()), 32'(e));
    chk(legal ? "R3 err" : "R7 err", 32'(reqErr), legal ? 32'd0 : 32'd1);
    if (legal) begin
      case (op)
        0: mOpen[bank] = 1'b1;
        3: if (ap) mOpen = 4'h0; else mOpen[bank] = 1'b0;
        5: if (bank == 0) begin
             if (row[2:0] == 3'd1) mBl = 2;
             else if (row[2:0] == 3'd2) mBl = 4;
             else if (row[2:0] == 3'd3) mBl = 8;
           end
        default: ;
      endcase
    end
    chk(legal ? opTag(op) : "R7 state", 32'(bankOpen), 32'(mOpen));
    if (legal && (op == 1 || op == 2)) begin
      chk("R9 ready low", 32'(reqReady), 32'd0);
      for (int k = 1; k < mBl / 2; k++) begin
        @(negedge clk);
        chk("R9 ready low", 32'(reqReady), 32'd0);
        chk("R3 deselect", 32'(pinsNow()), 32'(DESEL));
        chk("R9 open held", 32'(bankOpen), 32'(mOpen));
      end
      @(negedge clk);
      if (ap) mOpen[bank] = 1'b0;
      chk("R9 ready back", 32'(reqReady), 32'd1);
      chk("R9 auto close", 32'(bankOpen), 32'(mOpen));
    end else begin
      chk("R9 ready idle", 32'(reqReady), 32'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd20240611);
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqBank = '0;
    reqRow = '0; reqCol = '0; reqAutoPre = 1'b0;
    mOpen = 4'h0; mBl = 2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pins", 32'(pinsNow()), 32'(DESEL));
    chk("R1 err", 32'(reqErr), 32'd0);
    chk("R1 open", 32'(bankOpen), 32'd0);
    chk("R1 ready", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 idle deselect", 32'(pinsNow()), 32'(DESEL));

    doReq(1, 0, 13'h0, 11'h12, 1'b0);          // R7 read on closed bank
    doReq(0, 1, 13'h1ABC, 11'h0, 1'b0);        // R4 bank 1 -> ba=01
    doReq(0, 1, 13'h0123, 11'h0, 1'b0);        // R7 activate on open bank
    doReq(0, 2, 13'h0F0F, 11'h0, 1'b0);        // R4
    doReq(1, 1, 13'h0, 11'h7FF, 1'b0);         // R5 addr 0x0BFF, BL 2
    @(negedge clk);
    chk("R3 single cycle", 32'(pinsNow()), 32'(DESEL));
    doReq(4, 0, 13'h0, 11'h0, 1'b0);           // R8 refused while open
    doReq(5, 0, 13'h0003, 11'h0, 1'b0);        // R10 BL 8
    doReq(2, 2, 13'h0, 11'h400, 1'b1);         // R5 R9 addr 0x0C00, closes bank 2
    doReq(3, 1, 13'h0, 11'h0, 1'b0);           // R6 single
    doReq(4, 3, 13'h0, 11'h0, 1'b0);           // R8 accepted
    doReq(6, 0, 13'h0, 11'h0, 1'b0);           // R8 unused code
    doReq(7, 2, 13'h0, 11'h0, 1'b1);           // R8 unused code
    for (int b = 0; b < 4; b++) doReq(0, b, 13'(b * 13'h111), 11'h0, 1'b0);
    doReq(3, 2, 13'h0, 11'h0, 1'b1);           // R6 all banks
    doReq(5, 1, 13'h0002, 11'h0, 1'b0);        // R10 nonzero bank: BL stays 8
    doReq(0, 3, 13'h1FFF, 11'h0, 1'b0);
    doReq(1, 3, 13'h0, 11'h155, 1'b1);         // R9 window of 4
    doReq(5, 0, 13'h0004, 11'h0, 1'b0);        // R10 code 4 ignored
    doReq(5, 0, 13'h0002, 11'h0, 1'b0);        // R10 BL 4
    doReq(0, 0, 13'h0AAA, 11'h0, 1'b0);
    doReq(2, 0, 13'h0, 11'h2AA, 1'b0);         // R9 window of 2

    for (int n = 0; n < 500; n++) begin
      doReq(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
            13'($urandom), 11'($urandom), bit'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule